// File: doc/BRIEF.md
# Timeslot-16 Clear Channel Serialiser

This block lets E1 timeslot 16 carry an unstructured 64 kb/s user stream. On the transmit side it builds its own 64 kHz sampling clock from the system channel and frame strobes. It samples a serial input on every rising edge of that clock, which gives eight bits per 125 µs frame. It then holds the assembled byte for the framer to place into timeslot 16 of the following frame.

On the receive side the framer hands over the timeslot-16 byte of each received frame. The block stages that byte and shifts it out MSB first during the next receive frame. It drives a matching 64 kHz clock built the same way from the receive channel and frame strobes, so the serial output and its clock share the receive timebase.

A single enable chooses between clear-channel operation and normal operation. When the enable is low, the transmit byte falls back to the framer's ordinary timeslot-16 source and the serial output rests high. Channel-boundary and frame-start strobes arrive as one-cycle pulses of the block clock. A frame strobe coincides with the channel strobe of channel 0.

Top module: `ts16_clear_channel`

## Requirements
- R1: Each 64 kHz clock changes level only one cycle after a channel or frame strobe. It is high during channels whose index modulo 4 is 2 or 3 and low otherwise, so it toggles every second channel boundary.
- R2: In each frame, the first rising edge of each 64 kHz clock follows the strobe of channel 2, and the later edges follow channels 6, 10, …, 30, which gives eight per 32-channel frame.
- R3: The transmit input is sampled once per rising edge of the internal transmit clock. The first sample of a frame becomes bit 7 of the assembled byte and the eighth becomes bit 0.
- R4: A byte assembled from eight samples in a system frame is presented on `tx_ts16_data` from the start of the next system frame, and is held for that whole frame.
- R5: If a system frame ends after fewer than eight samples, the byte that was presented before it stays unchanged through the following frame.
- R6: While `cc_en` is low, `tx_ts16_data` equals `tx_ts16_norm`.
- R7: A byte taken in with `rx_ts16_stb` is shifted out on `rx_ser_out` MSB first during the next receive frame. Each bit is steady across a rising edge of `rx_clk64` and changes only after a falling edge.
- R8: `rx_clk64` follows the receive strobes with the phase given in R1 and R2.
- R9: While `cc_en` is low, `rx_ser_out` stays at 1.
- R10: After reset, `rx_ser_out` is 1, `rx_clk64` is 0 and the held transmit byte is 8'h00.
- R11: A receive byte arriving in the middle of a frame does not disturb the bits being shifted out in that frame. It takes effect only at the next receive frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cc_en | input | 1 | Clear-channel enable |
| sys_frame_stb | input | 1 | System frame start pulse (with channel 0 strobe) |
| sys_chan_stb | input | 1 | System channel boundary pulse |
| tx_ser_in | input | 1 | 64 kb/s transmit serial data |
| tx_ts16_norm | input | 8 | Ordinary timeslot-16 byte used when clear channel is off |
| tx_ts16_data | output | 8 | Byte for transmit timeslot 16 |
| rx_frame_stb | input | 1 | Receive frame start pulse (with channel 0 strobe) |
| rx_chan_stb | input | 1 | Receive channel boundary pulse |
| rx_ts16_stb | input | 1 | Marks a valid received timeslot-16 byte |
| rx_ts16_byte | input | 8 | Received timeslot-16 byte |
| rx_ser_out | output | 1 | 64 kb/s receive serial data |
| rx_clk64 | output | 1 | 64 kHz clock aligned with `rx_ser_out` |

## Verification
The transmit stream drives the complement of each bit in the first half of its four-channel slot. A sampling clock with the wrong phase, such as one that rises at channel 0, therefore assembles inverted bytes. A system frame is cut short to four samples: a design that loads a partial byte shows a mixed value instead of the previous one. One frame runs with the enable low, which exposes a mux that ignores the enable and a serial output that leaks staged data. The receive byte always arrives mid-frame, so a single buffer corrupts the second half of the byte being shifted out. Every rising edge of the receive clock is checked against its channel index.

// File: rtl/ts16cc_pkg.sv
package ts16cc_pkg;

  // Default frame geometry of a 2.048 Mb/s E1 timebase.
  localparam int CHANS_PER_FRAME = 32;
  localparam int CHANS_PER_HALF  = 2;   // channels per 64 kHz half period
  localparam int BITS_PER_FRAME  = 8;

  // Strobes derived from one channel/frame timebase.
  typedef struct packed {
    logic ck;     // 64 kHz clock level
    logic rise;   // first cycle with ck high
    logic fall;   // first cycle with ck low
    logic frame;  // first cycle of a frame
  } tb_tick_t;

endpackage

// File: rtl/ts16_rst_sync.sv
module ts16_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic s0_q;
  logic s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign rst_sync_n = s1_q;

endmodule

// File: rtl/ts16_clk64_gen.sv
module ts16_clk64_gen
  import ts16cc_pkg::*;
#(
  parameter int CHANS = CHANS_PER_FRAME,
  parameter int DIV   = CHANS_PER_HALF
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     frame_stb,
  input  logic     chan_stb,
  output tb_tick_t tick
);

  localparam int CW = $clog2(CHANS);

  logic [CW-1:0] ch_q;
  logic [CW-1:0] ch_d;
  logic [CW-1:0] grp;
  logic          ck_q;
  logic          ck_d;
  logic          rise_q;
  logic          fall_q;
  logic          frm_q;
  logic          upd;

  // Next-state: channel index and clock level derived from it.
  always_comb begin
    upd  = frame_stb | chan_stb;
    ch_d = ch_q;
    if (frame_stb) begin
      ch_d = '0;
    end else if (chan_stb) begin
      ch_d = (ch_q == CW'(CHANS - 1)) ? '0 : ch_q + 1'b1;
    end
    grp  = ch_d / CW'(DIV);
    ck_d = grp[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q   <= '0;
      ck_q   <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      frm_q  <= 1'b0;
    end else begin
      ch_q   <= ch_d;
      ck_q   <= ck_d;
      rise_q <= ck_d & ~ck_q;
      fall_q <= ~ck_d & ck_q;
      frm_q  <= frame_stb;
    end
  end

  assign tick = '{ck: ck_q, rise: rise_q, fall: fall_q, frame: frm_q};

  // R1: the clock moves only right after a boundary strobe
  p_ck_on_boundary_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ck_q) |-> $past(upd));

  // R2: every rising edge lands on the fixed channel phase
  p_rise_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |-> ((32'(ch_q) % (2 * DIV)) == DIV));

endmodule

// File: rtl/ts16_tx_packer.sv
module ts16_tx_packer
  import ts16cc_pkg::*;
#(
  parameter int BITS = BITS_PER_FRAME
) (
  input  logic            clk,
  input  logic            rst_n,
  input  tb_tick_t        tick,
  input  logic            ser_in,
  output logic [BITS-1:0] held
);

  localparam int NW = $clog2(BITS + 1);

  logic [BITS-1:0] sh_q;
  logic [BITS-1:0] sh_d;
  logic [BITS-1:0] held_q;
  logic [BITS-1:0] held_d;
  logic [NW-1:0]   cnt_q;
  logic [NW-1:0]   cnt_d;
  logic            full;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    held_d = held_q;
    full   = (cnt_q == NW'(BITS));
    if (tick.frame) begin
      if (full) begin
        held_d = sh_q;
      end
      cnt_d = '0;
    end else if (tick.rise) begin
      sh_d = {sh_q[BITS-2:0], ser_in};
      if (!full) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      held_q <= '0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      held_q <= held_d;
    end
  end

  assign held = held_q;

  // R4: the held byte only changes at a frame start
  p_held_at_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(held_q) |-> $past(tick.frame));

  // R5: a frame short of samples leaves the held byte alone
  p_short_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick.frame && (cnt_q != NW'(BITS))) |=> $stable(held_q));

  // R3: sampling happens on the rising edge, with the clock high
  p_sample_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick.rise |-> tick.ck);

  // R1: a falling strobe always sees the clock low
  p_fall_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick.fall |-> !tick.ck);

endmodule

// File: rtl/ts16_rx_serializer.sv
module ts16_rx_serializer
  import ts16cc_pkg::*;
#(
  parameter int BITS = BITS_PER_FRAME
) (
  input  logic            clk,
  input  logic            rst_n,
  input  tb_tick_t        tick,
  input  logic            en,
  input  logic            byte_stb,
  input  logic [BITS-1:0] byte_in,
  output logic            ser_out
);

  logic [BITS-1:0] stage_q;
  logic [BITS-1:0] stage_d;
  logic [BITS-1:0] sh_q;
  logic [BITS-1:0] sh_d;

  always_comb begin
    stage_d = byte_stb ? byte_in : stage_q;
    sh_d    = sh_q;
    if (tick.frame) begin
      sh_d = stage_q;
    end else if (tick.fall) begin
      sh_d = {sh_q[BITS-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '1;
      sh_q    <= '1;
    end else begin
      stage_q <= stage_d;
      sh_q    <= sh_d;
    end
  end

  assign ser_out = en ? sh_q[BITS-1] : 1'b1;

  // R7: the output bit never moves while the clock is high
  p_bit_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick.ck |-> $stable(sh_q));

  // R11: the shifter takes the staged byte at frame start
  p_frame_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tick.frame |=> (sh_q == $past(stage_q)));

  // R8: a rising strobe always sees the clock high
  p_rise_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick.rise |-> tick.ck);

endmodule

// File: rtl/ts16_clear_channel.sv
module ts16_clear_channel
  import ts16cc_pkg::*;
#(
  parameter int CHANS = CHANS_PER_FRAME,
  parameter int DIV   = CHANS_PER_HALF,
  parameter int BITS  = BITS_PER_FRAME
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cc_en,
  input  logic            sys_frame_stb,
  input  logic            sys_chan_stb,
  input  logic            tx_ser_in,
  input  logic [BITS-1:0] tx_ts16_norm,
  output logic [BITS-1:0] tx_ts16_data,
  input  logic            rx_frame_stb,
  input  logic            rx_chan_stb,
  input  logic            rx_ts16_stb,
  input  logic [BITS-1:0] rx_ts16_byte,
  output logic            rx_ser_out,
  output logic            rx_clk64
);

  logic            rst_sync_n;
  tb_tick_t        sys_tick;
  tb_tick_t        rx_tick;
  logic [BITS-1:0] tx_held;

  ts16_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ts16_clk64_gen #(.CHANS(CHANS), .DIV(DIV)) u_sys_tb (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .frame_stb (sys_frame_stb),
    .chan_stb  (sys_chan_stb),
    .tick      (sys_tick)
  );

  ts16_clk64_gen #(.CHANS(CHANS), .DIV(DIV)) u_rx_tb (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .frame_stb (rx_frame_stb),
    .chan_stb  (rx_chan_stb),
    .tick      (rx_tick)
  );

  ts16_tx_packer #(.BITS(BITS)) u_tx (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick   (sys_tick),
    .ser_in (tx_ser_in),
    .held   (tx_held)
  );

  ts16_rx_serializer #(.BITS(BITS)) u_rx (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (rx_tick),
    .en       (cc_en),
    .byte_stb (rx_ts16_stb),
    .byte_in  (rx_ts16_byte),
    .ser_out  (rx_ser_out)
  );

  assign tx_ts16_data = cc_en ? tx_held : tx_ts16_norm;
  assign rx_clk64     = rx_tick.ck;

endmodule

// File: tb/tb_ts16_clear_channel.sv
module tb_ts16_clear_channel;

  localparam int CHL     = 4;   // clocks per channel
  localparam int NCH     = 32;
  localparam int NFR     = 10;
  localparam int SHORT_F = 6;
  localparam int DIS_F   = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cc_en;
  logic       sys_frame_stb, sys_chan_stb, tx_ser_in;
  logic [7:0] tx_ts16_norm, tx_ts16_data;
  logic       rx_frame_stb, rx_chan_stb, rx_ts16_stb;
  logic [7:0] rx_ts16_byte;
  logic       rx_ser_out, rx_clk64;

  always #4 clk = ~clk;

  ts16_clear_channel dut (
    .clk(clk), .rst_n(rst_n), .cc_en(cc_en),
    .sys_frame_stb(sys_frame_stb), .sys_chan_stb(sys_chan_stb),
    .tx_ser_in(tx_ser_in), .tx_ts16_norm(tx_ts16_norm),
    .tx_ts16_data(tx_ts16_data),
    .rx_frame_stb(rx_frame_stb), .rx_chan_stb(rx_chan_stb),
    .rx_ts16_stb(rx_ts16_stb), .rx_ts16_byte(rx_ts16_byte),
    .rx_ser_out(rx_ser_out), .rx_clk64(rx_clk64)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [7:0] txq[$];
  int         rx_tag_q[$];
  logic [7:0] rx_val_q[$];
  bit         tx_probe = 1'b0;
  int         rx_cur_ch = 0;
  int         rx_cur_f  = -1;

  task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] txb(int f);
    if (f == 1) return 8'hFF;
    if (f == 4) return 8'h00;
    return 8'(f * 59 + 92);
  endfunction

  function automatic logic [7:0] rxb(int f);
    if (f == 5) return 8'h00;
    return 8'(f * 71 + 33);
  endfunction

  function automatic bit cc_on(int f);
    return f != DIS_F;
  endfunction

  function automatic int frame_len(int f);
    return (f == SHORT_F) ? 16 : NCH;
  endfunction

  // Driver: strobes, serial input and expected items
  initial begin
    logic [7:0] held;
    logic [7:0] cur;
    logic       b;
    int sc, sf, rc, rf, cyc, sys_cur_ch;
    rst_n = 1'b0; cc_en = 1'b1;
    sys_frame_stb = 0; sys_chan_stb = 0; tx_ser_in = 0; tx_ts16_norm = '0;
    rx_frame_stb = 0; rx_chan_stb = 0; rx_ts16_stb = 0; rx_ts16_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk8("R10 rx_ser_out", {7'b0, rx_ser_out}, 8'h01);
    chk8("R10 rx_clk64", {7'b0, rx_clk64}, 8'h00);
    chk8("R10 tx_ts16_data", tx_ts16_data, 8'h00);
    held = 8'h00; sc = 0; sf = 0; rc = 0; rf = 0; cyc = 0; sys_cur_ch = 0;
    while (sf < NFR) begin
      @(negedge clk);
      sys_frame_stb = 0; sys_chan_stb = 0;
      rx_frame_stb = 0; rx_chan_stb = 0; rx_ts16_stb = 0; tx_probe = 0;
      if ((cyc % CHL) == 0) begin
        if (sc == 0) begin
          if (sf > 0 && frame_len(sf - 1) == NCH) held = txb(sf - 1);
          cc_en = cc_on(sf);
          tx_ts16_norm = 8'hC3 ^ 8'(sf);
          txq.push_back(cc_on(sf) ? held : (8'hC3 ^ 8'(sf)));
          sys_frame_stb = 1;
        end
        sys_chan_stb = 1;
        cur = txb(sf);
        b = cur[7 - sc / 4];
        // junk (complement) in the first half of each slot
        tx_ser_in = ((sc % 4) >= 2) ? b : ~b;
        sys_cur_ch = sc;
        sc++;
        if (sc == frame_len(sf)) begin sc = 0; sf++; end
      end
      if ((cyc % CHL) == 2) begin
        if (rc == 0) begin rx_frame_stb = 1; rx_cur_f = rf; end
        rx_chan_stb = 1;
        rx_cur_ch = rc;
        if (rc == 16) begin
          rx_ts16_stb = 1;
          rx_ts16_byte = rxb(rf);
          rx_tag_q.push_back(rf + 1);
          rx_val_q.push_back(cc_on(rf + 1) ? rxb(rf) : 8'hFF);
        end
        rc++;
        if (rc == NCH) begin rc = 0; rf++; end
        if (sys_cur_ch == 10) tx_probe = 1;
      end
      cyc++;
    end
    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // Monitor: pops expected items and compares against the outputs
  initial begin
    logic       prev_ck;
    logic [7:0] acc;
    int         nb, bit_f;
    prev_ck = 1'b0; acc = '0; nb = 0; bit_f = -1;
    forever begin
      @(posedge clk);
      #2;
      if (rst_n) begin
        if (tx_probe && txq.size() > 0) begin
          chk8("R3 R4 R5 R6 tx_ts16_data", tx_ts16_data, txq.pop_front());
        end
        if (rx_clk64 && !prev_ck) begin
          // R1 R2 R8: rising edge only in channels 2 mod 4
          chk8("R8 R2 rise channel mod 4", 8'(rx_cur_ch % 4), 8'd2);
          if (rx_cur_f != bit_f) begin nb = 0; bit_f = rx_cur_f; end
          acc = {acc[6:0], rx_ser_out};
          nb++;
          if (nb == 8) begin
            while (rx_tag_q.size() > 0 && rx_tag_q[0] < bit_f) begin
              void'(rx_tag_q.pop_front());
              void'(rx_val_q.pop_front());
            end
            if (rx_tag_q.size() > 0 && rx_tag_q[0] == bit_f) begin
              void'(rx_tag_q.pop_front());
              chk8("R7 R9 R11 rx byte", acc, rx_val_q.pop_front());
            end
          end
        end
        prev_ck = rx_clk64;
      end
    end
  end

  // Watchdog
  initial begin
    #(200000 * 8);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule